// File: doc/BRIEF.md
# Gate Operator Logic Controller

This block is the sequencing brain of a motorised sliding or swing gate. It watches an open command contact, a stop contact, a closing-path photocell and two end-of-travel switches, and drives two mutually exclusive motor enables (toward open, toward closed), a flashing warning lamp, the photocell transmitter supply and a small set of indicator LEDs. Every contact is passed through a two-flop synchronizer and a debounce counter before the state machine sees it, and the open command acts only on its rising edge.

A configuration pin selects one of two operating logics. In automatic logic a single open pulse opens the gate, which then waits a pause time and recloses by itself. In semi-automatic logic each open pulse steps the gate along open, lock, close, with no reclose. A second configuration pin enables a photocell self-test before each motor start: the transmitter supply is switched off, the receiver must report a fault, then the supply is restored and the receiver must report clear; otherwise the start is abandoned.

Top module: `gate_operator`

## Requirements
- R1: After reset the gate reports state code 0 (closed), both motor enables and the lamp are low and the photocell transmitter supply is on. State codes: 0 closed, 1 opening, 2 open, 3 closing, 4 locked, 5 self-test with transmitter off, 6 self-test with transmitter on.
- R2: In automatic logic an open pulse moves closed to opening, has no effect during opening, and restarts the pause count while open.
- R3: In automatic logic the gate leaves open for closing once PAUSE_TICKS prescaled ticks have passed without an open pulse or safety activity.
- R4: In semi-automatic logic an open pulse moves closed to opening, opening to locked and open to closing, and the gate never recloses by itself.
- R5: In both logics an open pulse during closing reverses to opening, and an open pulse in locked starts closing.
- R6: An active stop (stop contact low) moves opening, open, closing and both self-test states to locked; while stop is active open pulses in closed or locked are ignored.
- R7: An active safety input (photocell contact low) during closing reverses to opening; it has no effect during opening or closed; while it is active no closing can start and, in automatic logic, the pause count is held at zero.
- R8: The open limit (high) ends opening in open and the closed limit (high) ends closing in closed; a stop in the same cycle wins over a limit, and a limit wins over an open pulse in the same cycle.
- R9: With self-test enabled, a start first enters state 5 with the transmitter supply off, then state 6 with it on, then the requested motion when the receiver read fault then clear.
- R10: With self-test enabled, a receiver that does not read fault with its transmitter off returns the gate to the state it started from and no motor runs.
- R11: A contact change shorter than DEB_CYCLES clock cycles is ignored, and an open contact held closed acts only once.
- R12: The lamp toggles once per prescaled tick while opening or closing and is low in every other state.
- R13: The LEDs show the debounced open, stop and safety contact levels (high means contact closed), and a test LED is high during states 5 and 6.
- R14: The open motor enable is high exactly in state 1 and the close motor enable exactly in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| openRaw | input | 1 | Open command contact, high when pressed |
| stopRaw | input | 1 | Stop contact, low when stop is requested |
| safetyRaw | input | 1 | Photocell receiver contact, low when the beam is broken or unpowered |
| limOpenRaw | input | 1 | Open end-of-travel switch, high at the limit |
| limClosedRaw | input | 1 | Closed end-of-travel switch, high at the limit |
| autoMode | input | 1 | 1 selects automatic logic, 0 semi-automatic |
| failSafeEn | input | 1 | 1 enables the photocell self-test before each start |
| motorOpen | output | 1 | Drive the motor toward open |
| motorClose | output | 1 | Drive the motor toward closed |
| lampOn | output | 1 | Flashing lamp drive |
| photoTxOn | output | 1 | Photocell transmitter supply enable |
| ledOpen | output | 1 | Debounced open contact level |
| ledStop | output | 1 | Debounced stop contact level |
| ledSafety | output | 1 | Debounced safety contact level |
| ledTest | output | 1 | Self-test in progress |
| stateCode | output | 3 | Current state code as listed in R1 |

## Verification
Two inputs that can reach the state machine in the very same cycle are a stop and an end-of-travel limit, and an open pulse and an end-of-travel limit. The bench provokes each by changing both raw contacts at the same clock edge; since both debouncers are identical, their clean levels change together. It judges the outcome from the settled state code: locked when stop meets the open limit during opening, closed when an open pulse meets the closed limit during closing.

// File: rtl/gate_pkg.sv
package gate_pkg;

  typedef enum logic [2:0] {
    ST_CLOSED   = 3'd0,
    ST_OPENING  = 3'd1,
    ST_OPEN     = 3'd2,
    ST_CLOSING  = 3'd3,
    ST_LOCKED   = 3'd4,
    ST_TEST_OFF = 3'd5,
    ST_TEST_ON  = 3'd6
  } gateState_t;

  // control -> datapath
  typedef struct packed {
    logic pauseRun;
    logic pauseClr;
    logic testClr;
    logic flashEn;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic openEdge;
    logic stopAct;
    logic safeAct;
    logic limOpen;
    logic limClosed;
    logic pauseDone;
    logic testDone;
  } dpStatus_t;

endpackage

// File: rtl/gate_debounce.sv
module gate_debounce #(
  parameter int WIDTH = 5,
  parameter int DEB_CYCLES = 1000,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] cleanOut
);

  localparam int CW = $clog2(DEB_CYCLES + 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic          syncA;
    logic          syncB;
    logic          cleanBit;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA    <= RST_VAL[i];
        syncB    <= RST_VAL[i];
        cleanBit <= RST_VAL[i];
        cnt      <= '0;
      end else begin
        syncA <= rawIn[i];
        syncB <= syncA;
        if (syncB == cleanBit) begin
          cnt <= '0;
        end else if (cnt == CW'(DEB_CYCLES - 1)) begin
          cleanBit <= syncB;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign cleanOut[i] = cleanBit;
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int DEB_CYCLES  = 1000,
  parameter int TICK_DIV    = 50000,
  parameter int PAUSE_TICKS = 30,
  parameter int TEST_CYCLES = 2008
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        openRaw,
  input  logic        stopRaw,
  input  logic        safetyRaw,
  input  logic        limOpenRaw,
  input  logic        limClosedRaw,
  input  ctrlStrobe_t strb,
  output dpStatus_t   status,
  output logic        lampOn,
  output logic        ledOpen,
  output logic        ledStop,
  output logic        ledSafety
);

  localparam int NIN = 5;
  localparam int TW  = $clog2(TICK_DIV + 1);
  localparam int PW  = $clog2(PAUSE_TICKS + 1);
  localparam int XW  = $clog2(TEST_CYCLES + 1);
  // bit order: open, stop, safety, limOpen, limClosed
  localparam logic [NIN-1:0] IDLE_LEVELS = 5'b00110;

  logic [NIN-1:0] rawVec;
  logic [NIN-1:0] cleanVec;
  logic           openPrev;
  logic [TW-1:0]  tickCnt;
  logic           tick;
  logic [PW-1:0]  pauseCnt;
  logic [XW-1:0]  testCnt;

  assign rawVec = {limClosedRaw, limOpenRaw, safetyRaw, stopRaw, openRaw};

  gate_debounce #(
    .WIDTH(NIN),
    .DEB_CYCLES(DEB_CYCLES),
    .RST_VAL(IDLE_LEVELS)
  ) deb_i (
    .clk(clk),
    .rstN(rstN),
    .rawIn(rawVec),
    .cleanOut(cleanVec)
  );

  assign tick = (tickCnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openPrev <= 1'b0;
      tickCnt  <= '0;
      pauseCnt <= '0;
      testCnt  <= '0;
      lampOn   <= 1'b0;
    end else begin
      openPrev <= cleanVec[0];
      tickCnt  <= tick ? '0 : tickCnt + 1'b1;

      if (strb.pauseClr) pauseCnt <= '0;
      else if (strb.pauseRun && tick && pauseCnt != PW'(PAUSE_TICKS))
        pauseCnt <= pauseCnt + 1'b1;

      if (strb.testClr) testCnt <= '0;
      else if (testCnt != XW'(TEST_CYCLES)) testCnt <= testCnt + 1'b1;

      if (!strb.flashEn) lampOn <= 1'b0;
      else if (tick) lampOn <= ~lampOn;
    end
  end

  assign status.openEdge  = cleanVec[0] & ~openPrev;
  assign status.stopAct   = ~cleanVec[1];
  assign status.safeAct   = ~cleanVec[2];
  assign status.limOpen   = cleanVec[3];
  assign status.limClosed = cleanVec[4];
  assign status.pauseDone = (pauseCnt == PW'(PAUSE_TICKS));
  assign status.testDone  = (testCnt == XW'(TEST_CYCLES));

  assign ledOpen   = cleanVec[0];
  assign ledStop   = cleanVec[1];
  assign ledSafety = cleanVec[2];

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoMode,
  input  logic        failSafeEn,
  input  dpStatus_t   status,
  output ctrlStrobe_t strb,
  output gateState_t  state
);

  gateState_t origin;
  gateState_t nxt;
  gateState_t originNxt;
  logic       pendClose;
  logic       pendNxt;
  logic       reqOpen;
  logic       reqClose;

  always_comb begin
    nxt       = state;
    originNxt = origin;
    pendNxt   = pendClose;
    reqOpen   = 1'b0;
    reqClose  = 1'b0;

    strb.testClr  = 1'b0;
    strb.flashEn  = (state == ST_OPENING) || (state == ST_CLOSING);
    strb.pauseRun = (state == ST_OPEN) && autoMode;
    strb.pauseClr = (state != ST_OPEN) || status.safeAct || status.openEdge;

    unique case (state)
      ST_CLOSED: begin
        if (status.openEdge && !status.stopAct) reqOpen = 1'b1;
      end
      ST_OPENING: begin
        if (status.stopAct) nxt = ST_LOCKED;
        else if (status.limOpen) nxt = ST_OPEN;
        else if (status.openEdge && !autoMode) nxt = ST_LOCKED;
      end
      ST_OPEN: begin
        if (status.stopAct) nxt = ST_LOCKED;
        else if (!status.safeAct) begin
          if (!autoMode && status.openEdge) reqClose = 1'b1;
          else if (autoMode && status.pauseDone && !status.openEdge) reqClose = 1'b1;
        end
      end
      ST_CLOSING: begin
        if (status.stopAct) nxt = ST_LOCKED;
        else if (status.limClosed) nxt = ST_CLOSED;
        else if (status.safeAct || status.openEdge) nxt = ST_OPENING;
      end
      ST_LOCKED: begin
        if (status.openEdge && !status.stopAct && !status.safeAct) reqClose = 1'b1;
      end
      ST_TEST_OFF: begin
        if (status.stopAct) nxt = ST_LOCKED;
        else if (status.testDone) begin
          if (status.safeAct) begin
            nxt          = ST_TEST_ON;
            strb.testClr = 1'b1;
          end else begin
            nxt = origin;
          end
        end
      end
      ST_TEST_ON: begin
        if (status.stopAct) nxt = ST_LOCKED;
        else if (status.testDone) begin
          if (!status.safeAct) nxt = pendClose ? ST_CLOSING : ST_OPENING;
          else nxt = origin;
        end
      end
      default: nxt = ST_CLOSED;
    endcase

    if (reqOpen || reqClose) begin
      if (failSafeEn) begin
        nxt          = ST_TEST_OFF;
        pendNxt      = reqClose;
        originNxt    = state;
        strb.testClr = 1'b1;
      end else begin
        nxt = reqClose ? ST_CLOSING : ST_OPENING;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_CLOSED;
      origin    <= ST_CLOSED;
      pendClose <= 1'b0;
    end else begin
      state     <= nxt;
      origin    <= originNxt;
      pendClose <= pendNxt;
    end
  end

endmodule

// File: rtl/gate_operator.sv
module gate_operator
  import gate_pkg::*;
#(
  parameter int DEB_CYCLES  = 1000,
  parameter int TICK_DIV    = 50000,
  parameter int PAUSE_TICKS = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       openRaw,
  input  logic       stopRaw,
  input  logic       safetyRaw,
  input  logic       limOpenRaw,
  input  logic       limClosedRaw,
  input  logic       autoMode,
  input  logic       failSafeEn,
  output logic       motorOpen,
  output logic       motorClose,
  output logic       lampOn,
  output logic       photoTxOn,
  output logic       ledOpen,
  output logic       ledStop,
  output logic       ledSafety,
  output logic       ledTest,
  output logic [2:0] stateCode
);

  // each self-test phase must outlast synchronizer plus debounce
  localparam int TEST_CYCLES = 2 * DEB_CYCLES + 8;

  ctrlStrobe_t strb;
  dpStatus_t   status;
  gateState_t  state;

  gate_datapath #(
    .DEB_CYCLES(DEB_CYCLES),
    .TICK_DIV(TICK_DIV),
    .PAUSE_TICKS(PAUSE_TICKS),
    .TEST_CYCLES(TEST_CYCLES)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .openRaw(openRaw),
    .stopRaw(stopRaw),
    .safetyRaw(safetyRaw),
    .limOpenRaw(limOpenRaw),
    .limClosedRaw(limClosedRaw),
    .strb(strb),
    .status(status),
    .lampOn(lampOn),
    .ledOpen(ledOpen),
    .ledStop(ledStop),
    .ledSafety(ledSafety)
  );

  gate_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .autoMode(autoMode),
    .failSafeEn(failSafeEn),
    .status(status),
    .strb(strb),
    .state(state)
  );

  assign motorOpen  = (state == ST_OPENING);
  assign motorClose = (state == ST_CLOSING);
  assign photoTxOn  = (state != ST_TEST_OFF);
  assign ledTest    = (state == ST_TEST_OFF) || (state == ST_TEST_ON);
  assign stateCode  = state;

endmodule

// File: rtl/gate_operator_sva.sv
module gate_operator_sva (
  input logic       clk,
  input logic       rstN,
  input logic       motorOpen,
  input logic       motorClose,
  input logic       lampOn,
  input logic       photoTxOn,
  input logic       ledStop,
  input logic       ledSafety,
  input logic [2:0] stateCode
);

  AST_MOTOR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(motorOpen && motorClose)); // R14

  AST_STOP_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!ledStop && stateCode inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6}) |=> (stateCode == 3'd4)); // R6

  AST_STOP_HOLDS_REST: assert property (@(posedge clk) disable iff (!rstN)
    (!ledStop && stateCode inside {3'd0, 3'd4}) |=> (stateCode == $past(stateCode))); // R6

  AST_SAFETY_REVERSES: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd3 && ledStop && !ledSafety) |=> (stateCode inside {3'd0, 3'd1})); // R7

  AST_LAMP_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !(motorOpen || motorClose) |=> !lampOn); // R12

  AST_TX_OFF_FROM_REST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(photoTxOn) |-> ($past(stateCode) inside {3'd0, 3'd2, 3'd4})); // R9

  AST_CLOSE_START_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(motorClose) |-> ($past(stateCode) inside {3'd2, 3'd4, 3'd6})); // R5

endmodule

bind gate_operator gate_operator_sva sva_i (
  .clk(clk),
  .rstN(rstN),
  .motorOpen(motorOpen),
  .motorClose(motorClose),
  .lampOn(lampOn),
  .photoTxOn(photoTxOn),
  .ledStop(ledStop),
  .ledSafety(ledSafety),
  .stateCode(stateCode)
);

// File: tb/gate_operator_tb_top.sv
module gate_operator_tb_top;

  localparam int DEB  = 3;
  localparam int TDIV = 16;
  localparam int PTK  = 8;
  localparam int HOLD = DEB + 6;

  localparam int EV_OPEN = 0;
  localparam int EV_STOP = 1;
  localparam int EV_SAFE = 2;
  localparam int EV_LIM  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       openRaw = 1'b0;
  logic       stopRaw = 1'b1;
  logic       beamBlocked = 1'b0;
  logic       cellStuck = 1'b0;
  logic       limOpenRaw = 1'b0;
  logic       limClosedRaw = 1'b0;
  logic       autoMode = 1'b0;
  logic       failSafeEn = 1'b0;
  logic       safetyRaw;
  logic       motorOpen, motorClose, lampOn, photoTxOn;
  logic       ledOpen, ledStop, ledSafety, ledTest;
  logic [2:0] stateCode;

  int checks = 0;
  int errors = 0;

  // photocell model: unpowered receiver reads the fault level (low)
  assign safetyRaw = cellStuck ? 1'b1 : (photoTxOn ? !beamBlocked : 1'b0);

  always #10 clk = ~clk;

  gate_operator #(
    .DEB_CYCLES(DEB),
    .TICK_DIV(TDIV),
    .PAUSE_TICKS(PTK)
  ) dut_i (
    .clk(clk), .rstN(rstN), .openRaw(openRaw), .stopRaw(stopRaw),
    .safetyRaw(safetyRaw), .limOpenRaw(limOpenRaw), .limClosedRaw(limClosedRaw),
    .autoMode(autoMode), .failSafeEn(failSafeEn), .motorOpen(motorOpen),
    .motorClose(motorClose), .lampOn(lampOn), .photoTxOn(photoTxOn),
    .ledOpen(ledOpen), .ledStop(ledStop), .ledSafety(ledSafety),
    .ledTest(ledTest), .stateCode(stateCode)
  );

  function automatic int modelNext(int s, int ev, bit au);
    int n = s;
    case (ev)
      EV_OPEN: case (s)
        0: n = 1;
        1: n = au ? 1 : 4;
        2: n = au ? 2 : 3;
        3: n = 1;
        4: n = 3;
        default: n = s;
      endcase
      EV_STOP: n = (s == 0) ? 0 : 4;
      EV_SAFE: n = (s == 3) ? 1 : s;
      EV_LIM:  n = (s == 1) ? 2 : ((s == 3) ? 0 : s);
      default: n = s;
    endcase
    return n;
  endfunction

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(bit au, bit fs);
    @(negedge clk);
    rstN = 1'b0;
    openRaw = 1'b0; stopRaw = 1'b1; beamBlocked = 1'b0; cellStuck = 1'b0;
    limOpenRaw = 1'b0; limClosedRaw = 1'b0;
    autoMode = au; failSafeEn = fs;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(DEB + 8);
  endtask

  task automatic pulseEv(int ev);
    bit useOpenLim = (stateCode == 3'd1);
    case (ev)
      EV_OPEN: openRaw = 1'b1;
      EV_STOP: stopRaw = 1'b0;
      EV_SAFE: beamBlocked = 1'b1;
      default: if (useOpenLim) limOpenRaw = 1'b1; else limClosedRaw = 1'b1;
    endcase
    waitCyc(HOLD);
    openRaw = 1'b0; stopRaw = 1'b1; beamBlocked = 1'b0;
    limOpenRaw = 1'b0; limClosedRaw = 1'b0;
    waitCyc(HOLD);
  endtask

  task automatic randomRun(bit au, int steps);
    int exp = 0;
    doReset(au, 1'b0);
    for (int i = 0; i < steps; i++) begin
      int ev = $urandom % 4;
      if (au && exp == 2) ev = $urandom % 3;
      pulseEv(ev);
      exp = modelNext(exp, ev, au);
      check(au ? "R2 random auto state" : "R4 random semi state", stateCode, exp);
      check("R14 motorOpen", motorOpen, exp == 1);
      check("R14 motorClose", motorClose, exp == 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int toggles;
    logic prevLamp;
    void'($urandom(32'd2024));

    // ---------------- semi-automatic directed ----------------
    doReset(1'b0, 1'b0);
    check("R1 state", stateCode, 0);
    check("R1 motors", motorOpen | motorClose, 0);
    check("R1 lamp", lampOn, 0);
    check("R1 tx", photoTxOn, 1);
    check("R13 ledOpen idle", ledOpen, 0);
    check("R13 ledStop idle", ledStop, 1);
    check("R13 ledSafety idle", ledSafety, 1);
    check("R13 ledTest idle", ledTest, 0);

    // R11 glitch shorter than debounce
    openRaw = 1'b1; waitCyc(2); openRaw = 1'b0; waitCyc(20);
    check("R11 glitch ignored", stateCode, 0);
    check("R11 ledOpen after glitch", ledOpen, 0);

    // R6 stop held inhibits opening; R13 stop LED
    stopRaw = 1'b0; waitCyc(HOLD);
    check("R13 ledStop active", ledStop, 0);
    pulseEv(EV_OPEN);
    check("R6 stop inhibits open", stateCode, 0);
    stopRaw = 1'b1; waitCyc(HOLD);

    // R11 held open acts once
    openRaw = 1'b1; waitCyc(HOLD);
    check("R13 ledOpen pressed", ledOpen, 1);
    waitCyc(60);
    check("R11 held open acts once", stateCode, 1);
    check("R14 motorOpen in opening", motorOpen, 1);
    openRaw = 1'b0; waitCyc(HOLD);

    // R12 lamp rate
    toggles = 0; prevLamp = lampOn;
    for (int i = 0; i < 10 * TDIV; i++) begin
      waitCyc(1);
      if (lampOn != prevLamp) toggles++;
      prevLamp = lampOn;
    end
    check("R12 lamp toggles per tick", (toggles >= 9 && toggles <= 11), 1);

    pulseEv(EV_SAFE);
    check("R7 safety no effect in opening", stateCode, 1);
    pulseEv(EV_OPEN);
    check("R4 open in opening locks", stateCode, 4);
    pulseEv(EV_OPEN);
    check("R5 open in locked closes", stateCode, 3);
    check("R14 motorClose in closing", motorClose, 1);
    pulseEv(EV_SAFE);
    check("R7 safety reverses closing", stateCode, 1);
    pulseEv(EV_LIM);
    check("R8 open limit ends opening", stateCode, 2);
    waitCyc(3 * PTK * TDIV);
    check("R4 no automatic reclose", stateCode, 2);
    check("R12 lamp off when open", lampOn, 0);

    beamBlocked = 1'b1; waitCyc(HOLD);
    check("R13 ledSafety blocked", ledSafety, 0);
    pulseEv(EV_OPEN);
    check("R7 safety held blocks closing", stateCode, 2);
    beamBlocked = 1'b0; waitCyc(HOLD);
    pulseEv(EV_OPEN);
    check("R4 open in open closes", stateCode, 3);
    pulseEv(EV_OPEN);
    check("R5 open reverses closing", stateCode, 1);

    // R8 stop and open limit same cycle
    stopRaw = 1'b0; limOpenRaw = 1'b1; waitCyc(HOLD);
    check("R8 stop beats limit", stateCode, 4);
    stopRaw = 1'b1; limOpenRaw = 1'b0; waitCyc(HOLD);
    check("R6 stays locked after release", stateCode, 4);
    pulseEv(EV_OPEN);
    check("R5 locked to closing", stateCode, 3);
    // R8 open pulse and closed limit same cycle
    openRaw = 1'b1; limClosedRaw = 1'b1; waitCyc(HOLD);
    check("R8 limit beats open pulse", stateCode, 0);
    openRaw = 1'b0; limClosedRaw = 1'b0; waitCyc(HOLD);
    check("R8 closed after release", stateCode, 0);
    check("R12 lamp off when closed", lampOn, 0);

    // ---------------- automatic directed ----------------
    doReset(1'b1, 1'b0);
    pulseEv(EV_OPEN);
    check("R2 closed to opening", stateCode, 1);
    pulseEv(EV_OPEN);
    check("R2 open pulse no effect in opening", stateCode, 1);
    pulseEv(EV_LIM);
    check("R8 auto open limit", stateCode, 2);
    waitCyc(80);
    check("R3 still pausing", stateCode, 2);
    pulseEv(EV_OPEN);
    waitCyc(80);
    check("R2 open pulse restarts pause", stateCode, 2);
    waitCyc(60);
    check("R3 auto reclose", stateCode, 3);
    pulseEv(EV_OPEN);
    check("R5 auto reverse", stateCode, 1);
    pulseEv(EV_LIM);
    check("R8 auto open limit again", stateCode, 2);
    beamBlocked = 1'b1; waitCyc(200);
    check("R7 safety holds pause", stateCode, 2);
    beamBlocked = 1'b0; waitCyc(80);
    check("R7 pause restarted after safety", stateCode, 2);
    waitCyc(60);
    check("R3 reclose after safety", stateCode, 3);
    pulseEv(EV_LIM);
    check("R8 closed limit ends closing", stateCode, 0);

    // ---------------- self-test ----------------
    doReset(1'b0, 1'b1);
    openRaw = 1'b1; waitCyc(10);
    check("R9 test phase off", stateCode, 5);
    check("R9 tx off in test", photoTxOn, 0);
    check("R13 ledTest in test", ledTest, 1);
    check("R9 no motor in test", motorOpen | motorClose, 0);
    openRaw = 1'b0; waitCyc(40);
    check("R9 passed test opens", stateCode, 1);
    check("R9 tx back on", photoTxOn, 1);
    pulseEv(EV_LIM);
    check("R8 open limit after test", stateCode, 2);
    cellStuck = 1'b1;
    pulseEv(EV_OPEN);
    waitCyc(40);
    check("R10 failed test returns to open", stateCode, 2);
    check("R10 no motor after failed test", motorClose, 0);
    cellStuck = 1'b0;
    pulseEv(EV_OPEN);
    waitCyc(40);
    check("R9 healthy cell closes", stateCode, 3);

    // ---------------- constrained random ----------------
    randomRun(1'b0, 150);
    randomRun(1'b1, 150);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule